// File: doc/BRIEF.md
# Registered Parity Generator with Serial Shift

This block reduces a 12-bit data word to a single odd-parity bit and drives it straight out as a combinational result. A force input can pull that result low whatever the data. The same result also feeds a one-bit output register. A small selector in front of the register picks what the register takes on each capture: a fresh parity result, its own present value, or a serial input bit. With the serial source selected, successive captures move a bit stream through the register.

The register captures on a rising edge of either of two clock inputs, or of both at once. The two clocks are merged by an OR into one capture clock. An active-high reset clears the register at once, without waiting for any edge. Both the direct result and the registered result are also driven in inverted form. A typical use is to check a word's parity combinationally, log the result at a chosen moment, or splice a serial bit into the registered path.

Top module: `parityShiftReg`

## Requirements
- R1: With `forceLow` = 0, `parOut` is 1 exactly when the number of ones in `dataIn` is odd, and 0 when that number is even.
- R2: With `forceLow` = 1, `parOut` is 0 for every value of `dataIn`.
- R3: With `holdN` = 0 at a capture edge, `regOut` keeps its value, whatever the values of `shiftEn` and `serialIn` (hold takes priority over shift).
- R4: With `holdN` = 1 and `shiftEn` = 1 at a capture edge, `regOut` takes the value of `serialIn`.
- R5: With `holdN` = 1 and `shiftEn` = 0 at a capture edge, `regOut` takes the value `parOut` had before the edge, including the forced 0 when `forceLow` = 1.
- R6: A capture edge is a rising edge of `clkA` alone, of `clkB` alone, or of both together. When neither clock rises, `regOut` does not change while the inputs change.
- R7: With `rst` = 1, `regOut` becomes 0 at once, with no clock edge, and stays 0 while `rst` stays high.
- R8: `parOutN` is always the inverse of `parOut`, and `regOutN` is always the inverse of `regOut`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkA | input | 1 | First capture clock, rising edge |
| clkB | input | 1 | Second capture clock, rising edge; ORed with clkA |
| rst | input | 1 | Asynchronous register clear, active high |
| dataIn | input | 12 | Data word whose parity is computed |
| forceLow | input | 1 | When 1, forces the direct parity output to 0 |
| holdN | input | 1 | When 0, the register keeps its value |
| shiftEn | input | 1 | When 1 (and holdN = 1), the register takes serialIn |
| serialIn | input | 1 | Serial bit loaded in shift mode |
| parOut | output | 1 | Direct parity result, 1 on odd count |
| parOutN | output | 1 | Inverse of parOut |
| regOut | output | 1 | Registered output |
| regOutN | output | 1 | Inverse of regOut |

## Verification
On every capture edge, assertions check the three selector outcomes: hold keeps the value, shift takes the serial bit, and reload takes the previous direct result. On every cycle they also check that reset leaves the register at 0 and that the force input holds the direct output low. Only the bench scenarios can show some of the behaviour. These are the parity value itself over many data words, the clear that happens at once with no edge present, the fact that either clock or both together cause a capture, and the absence of change when no clock rises. The bench also checks the inverted outputs at the ports.

// File: rtl/parity_pkg.sv
package parity_pkg;
  localparam int unsigned DATA_W = 12;

  // Strobes from control to datapath; exactly one is set.
  typedef struct packed {
    logic keep;
    logic takeSerial;
    logic takeParity;
  } regStrobes_t;
endpackage

// File: rtl/parityCtrl.sv
module parityCtrl
  import parity_pkg::*;
(
  input  logic        holdN,
  input  logic        shiftEn,
  output regStrobes_t strb
);
  always_comb begin
    strb = '0;
    if (!holdN)       strb.keep       = 1'b1;  // hold wins over shift
    else if (shiftEn) strb.takeSerial = 1'b1;
    else              strb.takeParity = 1'b1;
  end
endmodule

// File: rtl/parityDatapath.sv
module parityDatapath
  import parity_pkg::*;
#(
  parameter int unsigned WIDTH = DATA_W
) (
  input  logic             clkAny,
  input  logic             rst,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             forceLow,
  input  logic             serialIn,
  input  regStrobes_t      strb,
  output logic             parOut,
  output logic             regQ
);
  localparam int unsigned LAST = WIDTH - 1;

  // Running XOR chain built by generate.
  logic [LAST:0] chain;
  assign chain[0] = dataIn[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_chain
    assign chain[i] = chain[i-1] ^ dataIn[i];
  end

  assign parOut = chain[LAST] & ~forceLow;

  always_comb begin
    if (forceLow) begin
      AST_FORCE_LOW: assert (parOut == 1'b0); // R2
    end
  end

  logic nextQ;
  always_comb begin
    nextQ = regQ;
    if (strb.takeSerial)      nextQ = serialIn;
    else if (strb.takeParity) nextQ = parOut;
  end

  always_ff @(posedge clkAny or posedge rst) begin
    if (rst) regQ <= 1'b0;
    else     regQ <= nextQ;
  end

  AST_RST_CLEAR: assert property (@(posedge clkAny) rst |-> !regQ); // R7
endmodule

// File: rtl/parityShiftReg.sv
module parityShiftReg
  import parity_pkg::*;
(
  input  logic              clkA,
  input  logic              clkB,
  input  logic              rst,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              forceLow,
  input  logic              holdN,
  input  logic              shiftEn,
  input  logic              serialIn,
  output logic              parOut,
  output logic              parOutN,
  output logic              regOut,
  output logic              regOutN
);
  logic        clkAny;
  regStrobes_t strb;

  // Either clock captures; clocks are assumed glitch-free when merged.
  assign clkAny = clkA | clkB;

  parityCtrl u_ctrl (
    .holdN   (holdN),
    .shiftEn (shiftEn),
    .strb    (strb)
  );

  parityDatapath #(.WIDTH(DATA_W)) u_dp (
    .clkAny   (clkAny),
    .rst      (rst),
    .dataIn   (dataIn),
    .forceLow (forceLow),
    .serialIn (serialIn),
    .strb     (strb),
    .parOut   (parOut),
    .regQ     (regOut)
  );

  assign parOutN = ~parOut;
  assign regOutN = ~regOut;

  AST_HOLD_KEEP: assert property (@(posedge clkAny) disable iff (rst)
    !holdN |=> regOut == $past(regOut)); // R3
  AST_SHIFT_LOAD: assert property (@(posedge clkAny) disable iff (rst)
    (holdN && shiftEn) |=> regOut == $past(serialIn)); // R4
  AST_RELOAD_PAR: assert property (@(posedge clkAny) disable iff (rst)
    (holdN && !shiftEn) |=> regOut == $past(parOut)); // R5
endmodule

// File: tb/tb_parityShiftReg.sv
module tb_parityShiftReg;
  logic clk = 1'b0;
  logic useA = 1'b0, useB = 1'b0;
  logic clkA, clkB, rst;
  logic [11:0] dataIn;
  logic forceLow, holdN, shiftEn, serialIn;
  logic parOut, parOutN, regOut, regOutN;
  int nChecks = 0, nFails = 0;

  always #4 clk = ~clk;  // 125 MHz
  assign clkA = clk & useA;
  assign clkB = clk & useB;

  parityShiftReg dut (
    .clkA(clkA), .clkB(clkB), .rst(rst), .dataIn(dataIn),
    .forceLow(forceLow), .holdN(holdN), .shiftEn(shiftEn),
    .serialIn(serialIn), .parOut(parOut), .parOutN(parOutN),
    .regOut(regOut), .regOutN(regOutN)
  );

  task automatic check(input string req, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic refParity(input logic [11:0] d);
    int ones = 0;
    for (int i = 0; i < 12; i++) if (d[i]) ones++;
    return (ones % 2) == 1;
  endfunction

  // One rising edge on the selected clocks; returns at the following negedge.
  task automatic tick(input logic a, input logic b);
    @(negedge clk); useA = a; useB = b;
    @(negedge clk); useA = 1'b0; useB = 1'b0;
  endtask

  task automatic testReset();
    check("R7 reset", regOut, 1'b0);
    check("R8 regOutN at reset", regOutN, 1'b1);
  endtask

  task automatic testParity();
    forceLow = 1'b0;
    for (int k = 0; k < 24; k++) begin
      dataIn = (k == 0) ? 12'h000 : (k == 1) ? 12'hFFF : (k == 2) ? 12'h800 : 12'($urandom);
      #1;
      check("R1 parity", parOut, refParity(dataIn));
      check("R8 parOutN", parOutN, ~refParity(dataIn));
    end
  endtask

  task automatic testForce();
    forceLow = 1'b1;
    for (int k = 0; k < 8; k++) begin
      dataIn = (k == 0) ? 12'h001 : 12'($urandom);
      #1;
      check("R2 force low", parOut, 1'b0);
    end
    forceLow = 1'b0;
  endtask

  task automatic testReload();
    holdN = 1'b1; shiftEn = 1'b0;
    dataIn = 12'h007; forceLow = 1'b0;
    tick(1'b1, 1'b0);
    check("R5 reload odd", regOut, 1'b1);
    dataIn = 12'h003;
    tick(1'b1, 1'b0);
    check("R5 reload even", regOut, 1'b0);
    dataIn = 12'h001;
    tick(1'b0, 1'b1);
    check("R5 reload odd via clkB", regOut, 1'b1);
    forceLow = 1'b1;
    tick(1'b1, 1'b0);
    check("R5 reload forced", regOut, 1'b0);
    forceLow = 1'b0;
  endtask

  task automatic testShift();
    logic [3:0] pat = 4'b1101;
    holdN = 1'b1; shiftEn = 1'b1; dataIn = 12'h000;
    for (int k = 0; k < 4; k++) begin
      serialIn = pat[k];
      tick(1'b0, 1'b1);
      check("R4 shift bit", regOut, pat[k]);
      check("R8 regOutN", regOutN, ~pat[k]);
    end
  endtask

  task automatic testHold();
    holdN = 1'b1; shiftEn = 1'b1; serialIn = 1'b1;
    tick(1'b1, 1'b0);
    holdN = 1'b0; serialIn = 1'b0; dataIn = 12'h000;
    tick(1'b1, 1'b1);
    check("R3 hold over shift", regOut, 1'b1);
    shiftEn = 1'b0;
    tick(1'b0, 1'b1);
    check("R3 hold over reload", regOut, 1'b1);
    holdN = 1'b1;
  endtask

  task automatic testClocks();
    holdN = 1'b1; shiftEn = 1'b1;
    serialIn = 1'b0; tick(1'b1, 1'b1);
    check("R6 both clocks", regOut, 1'b0);
    serialIn = 1'b1; tick(1'b1, 1'b0);
    check("R6 clkA alone", regOut, 1'b1);
    serialIn = 1'b0; tick(1'b0, 1'b1);
    check("R6 clkB alone", regOut, 1'b0);
    serialIn = 1'b1; tick(1'b0, 1'b0);
    check("R6 no edge no change", regOut, 1'b0);
  endtask

  task automatic testAsyncReset();
    holdN = 1'b1; shiftEn = 1'b1; serialIn = 1'b1;
    tick(1'b1, 1'b0);
    check("R4 preload one", regOut, 1'b1);
    @(negedge clk); #1;
    rst = 1'b1; #1;
    check("R7 async clear", regOut, 1'b0);
    tick(1'b1, 1'b1);
    check("R7 held during reset", regOut, 1'b0);
    rst = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    nChecks++; nFails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    rst = 1'b1; dataIn = '0; forceLow = 1'b0; holdN = 1'b1;
    shiftEn = 1'b0; serialIn = 1'b0;
    repeat (2) @(negedge clk);
    testReset();
    rst = 1'b0;
    testParity();
    testForce();
    testReload();
    testShift();
    testHold();
    testClocks();
    testAsyncReset();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule